// File: doc/BRIEF.md
# Phase-Slot Programmable Clock Generator

The block derives an output clock from a reference period that is cut into 32 equal phase slots. A fast system clock, running at 32 ticks per reference period, advances a phase counter. A one-cycle reference-edge pulse, already synchronous to that clock, resets the counter to slot 0.

An 8-bit setting selects a fraction of the period in steps of 1/32. Its top two bits choose a quarter of the period. One of two 3-bit fine fields then chooses the step within that quarter. The low fine field serves the lower two quarters and the middle fine field serves the upper two.

A separate mode setting chooses what the fraction means:
- In duty form it is the high time of the output.
- In double-rate duty form it gives two pulses per reference period.
- In shifted form it is the position of the rising edge of a half-period-wide pulse.

Both settings are written through a small write port. They become active only at the next reference edge, so a change never cuts a pulse short.

Top module: `slot_clkgen`

## Requirements
- R1: The slot count N equals 8 × duty[7:6] + fine + 1. In plain duty form (mode bit 0 = 0, bit 4 = 0), the output is high in exactly the N slots 0..N-1 of each period. For example, duty 0x64 gives 13 high slots and duty 0xF0 gives 31.
- R2: When duty[7:6] is 00 or 01, the fine value is duty[2:0], and duty[5:3] has no effect on the output.
- R3: When duty[7:6] is 10 or 11, the fine value is duty[5:3], and duty[2:0] has no effect on the output.
- R4: A computed count of 32 (duty 0xF8 to 0xFF) is limited to 31, so in plain duty form the output is always low in slot 31.
- R5: With mode bit 4 = 1 and bit 0 = 0, the output is high while the phase count modulo 16 is below N/2 (N shifted right by one). This gives two pulses per period.
- R6: With mode bit 0 = 1, the output is high while (phase − N) mod 32 is below 16, so it rises at slot N. In this form, mode bit 4 has no effect.
- R7: A write with wrAddr = 0 stores the duty setting and a write with wrAddr = 1 stores the mode setting. Mode bits 1, 2, 3 and 7:5 are ignored. A stored value does not change the output until the next reference edge.
- R8: A reference-edge pulse puts the phase counter at slot 0; otherwise the counter advances by one and wraps from 31 to 0. The output is registered: the value for slot p appears one clock after the counter holds p.
- R9: A synchronous reset sets duty to 0x47 (16 slots) and mode to 0, and holds the output low while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, 32 ticks per reference period |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe for the settings |
| wrAddr | input | 1 | 0 selects the duty setting, 1 selects the mode setting |
| wrData | input | 8 | Write data |
| refEdge | input | 1 | One-cycle pulse marking the reference edge |
| clkOut | output | 1 | Generated clock |

## Verification
The bench builds the block with its default 3-bit fine fields, which gives 32 slots and an 8-bit setting. At that size, every one of the 256 duty codes can be swept under each of the four mode-bit combinations. For every code, the bench writes junk into the reserved mode bits and checks a full deferral window before the reference edge. It then checks a whole committed period cycle by cycle against an arithmetic model. Explicit high-time counts, a clamped top code and an early reference edge complete the set.

// File: rtl/slot_clkgen_pkg.sv
package slot_clkgen_pkg;

  typedef struct packed {
    logic restart;
    logic clear;
  } strobe_t;

  localparam int MODE_SHIFT_BIT  = 0;
  localparam int MODE_DOUBLE_BIT = 4;

endpackage

// File: rtl/slot_clkgen_ctrl.sv
module slot_clkgen_ctrl
  import slot_clkgen_pkg::*;
#(
  parameter int FINE_W = 3,
  localparam int DUTY_W = 2 + 2 * FINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [DUTY_W-1:0] wrData,
  input  logic              refEdge,
  output logic [DUTY_W-1:0] actDuty,
  output logic              actShift,
  output logic              actDouble,
  output strobe_t           strobe
);

  localparam logic [DUTY_W-1:0] DUTY_RST = {2'b01, {FINE_W{1'b0}}, {FINE_W{1'b1}}};

  logic [DUTY_W-1:0] pendDuty;
  logic              pendShift;
  logic              pendDouble;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendDuty   <= DUTY_RST;
      pendShift  <= 1'b0;
      pendDouble <= 1'b0;
    end else if (wrEn) begin
      if (!wrAddr) begin
        pendDuty <= wrData;
      end else begin
        pendShift  <= wrData[MODE_SHIFT_BIT];
        pendDouble <= wrData[MODE_DOUBLE_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      actDuty   <= DUTY_RST;
      actShift  <= 1'b0;
      actDouble <= 1'b0;
    end else if (refEdge) begin
      actDuty   <= pendDuty;
      actShift  <= pendShift;
      actDouble <= pendDouble;
    end
  end

  always_comb begin
    strobe.restart = refEdge & ~rst;
    strobe.clear   = rst;
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !refEdge |=> ($stable(actDuty) && $stable(actShift) && $stable(actDouble))); // R7

endmodule

// File: rtl/slot_clkgen_dpath.sv
module slot_clkgen_dpath
  import slot_clkgen_pkg::*;
#(
  parameter int FINE_W = 3,
  localparam int DUTY_W  = 2 + 2 * FINE_W,
  localparam int PHASE_W = FINE_W + 2
) (
  input  logic              clk,
  input  strobe_t           strobe,
  input  logic [DUTY_W-1:0] duty,
  input  logic              shiftMode,
  input  logic              doubleRate,
  output logic              clkOut
);

  localparam int NW = PHASE_W + 1;

  logic [PHASE_W-1:0] phase;
  logic [1:0]         quarter;
  logic [FINE_W-1:0]  fine;
  logic [NW-1:0]      rawCount;
  logic [PHASE_W-1:0] slotN;
  logic [PHASE_W-2:0] halfN;
  logic [PHASE_W-1:0] delta;
  logic               dutyHigh;
  logic               doubleHigh;
  logic               shiftHigh;
  logic               nextOut;

  always_comb begin
    quarter  = duty[DUTY_W-1 -: 2];
    fine     = quarter[1] ? duty[2*FINE_W-1:FINE_W] : duty[FINE_W-1:0];
    rawCount = {1'b0, quarter, fine} + NW'(1);
    slotN    = rawCount[PHASE_W] ? {PHASE_W{1'b1}} : rawCount[PHASE_W-1:0];
    halfN    = slotN[PHASE_W-1:1];
  end

  always_comb begin
    delta      = phase - slotN;
    dutyHigh   = (phase < slotN);
    doubleHigh = (phase[PHASE_W-2:0] < halfN);
    shiftHigh  = ~delta[PHASE_W-1];
    if (shiftMode)       nextOut = shiftHigh;
    else if (doubleRate) nextOut = doubleHigh;
    else                 nextOut = dutyHigh;
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      phase  <= '0;
      clkOut <= 1'b0;
    end else begin
      phase  <= strobe.restart ? '0 : phase + PHASE_W'(1);
      clkOut <= nextOut;
    end
  end

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (strobe.clear)
    (!strobe.restart && phase == {PHASE_W{1'b1}}) |=> (phase == '0)); // R8

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (strobe.clear)
    strobe.restart |=> (phase == '0)); // R8

  AST_RESET_LOW: assert property (@(posedge clk)
    strobe.clear |=> !clkOut); // R9

  AST_DUTY_END_LOW: assert property (@(posedge clk) disable iff (strobe.clear)
    (phase == {PHASE_W{1'b1}} && !shiftMode && !doubleRate) |=> !clkOut); // R4

  AST_SHIFT_RISE: assert property (@(posedge clk) disable iff (strobe.clear)
    (shiftMode && phase == slotN) |=> clkOut); // R6

endmodule

// File: rtl/slot_clkgen.sv
module slot_clkgen
  import slot_clkgen_pkg::*;
#(
  parameter int FINE_W = 3,
  localparam int DUTY_W = 2 + 2 * FINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [DUTY_W-1:0] wrData,
  input  logic              refEdge,
  output logic              clkOut
);

  strobe_t           strobe;
  logic [DUTY_W-1:0] actDuty;
  logic              actShift;
  logic              actDouble;

  slot_clkgen_ctrl #(.FINE_W(FINE_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .refEdge   (refEdge),
    .actDuty   (actDuty),
    .actShift  (actShift),
    .actDouble (actDouble),
    .strobe    (strobe)
  );

  slot_clkgen_dpath #(.FINE_W(FINE_W)) u_dpath (
    .clk        (clk),
    .strobe     (strobe),
    .duty       (actDuty),
    .shiftMode  (actShift),
    .doubleRate (actDouble),
    .clkOut     (clkOut)
  );

endmodule

// File: tb/slot_clkgen_tb.sv
module slot_clkgen_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       wrEn;
  logic       wrAddr;
  logic [7:0] wrData;
  logic       refEdge;
  logic       clkOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int   mPhase;
  int   mDuty, mShift, mDouble;
  int   sDuty, sShift, sDouble;
  logic mOut;
  string tagOverride = "";

  always #4 clk = ~clk;

  slot_clkgen u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .refEdge(refEdge), .clkOut(clkOut)
  );

  function automatic int slotsOf(int duty);
    int q = (duty >> 6) & 3;
    int fine = (q >= 2) ? ((duty >> 3) & 7) : (duty & 7);
    int n = q * 8 + fine + 1;
    if (n > 31) n = 31;
    return n;
  endfunction

  function automatic logic expectOut(int phase, int duty, int shiftM, int dbl);
    int n = slotsOf(duty);
    if (shiftM != 0) return (((phase - n + 32) % 32) < 16);
    if (dbl != 0)    return ((phase % 16) < (n / 2));
    return (phase < n);
  endfunction

  function automatic string tagNow();
    if (tagOverride != "") return tagOverride;
    if (mShift != 0)  return "R6";
    if (mDouble != 0) return "R5";
    if (((mDuty >> 6) & 3) >= 2) return "R3";
    return "R2";
  endfunction

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
    end
  endtask

  task automatic step(input logic re, input logic we, input logic a, input logic [7:0] d);
    logic nOut;
    int   nPhase;
    rst = 1'b0; refEdge = re; wrEn = we; wrAddr = a; wrData = d;
    nOut   = expectOut(mPhase, mDuty, mShift, mDouble);
    nPhase = re ? 0 : (mPhase + 1) % 32;
    if (re) begin
      mDuty = sDuty; mShift = sShift; mDouble = sDouble;
    end
    if (we) begin
      if (!a) sDuty = d;
      else begin
        sShift = d[0]; sDouble = d[4];
      end
    end
    @(posedge clk);
    mPhase = nPhase; mOut = nOut;
    @(negedge clk);
    check(tagNow(), clkOut, mOut);
    refEdge = 1'b0; wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic configure(input int duty, input int shiftM, input int dbl);
    step(1'b0, 1'b1, 1'b0, duty[7:0]);
    step(1'b0, 1'b1, 1'b1, {3'b101, dbl[0], 3'b111, shiftM[0]});
  endtask

  task automatic countHigh(input int duty, input int expected, input string tag);
    int highs = 0;
    configure(duty, 0, 0);
    idle(30);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    for (int i = 0; i < 32; i++) begin
      step(1'b0, 1'b0, 1'b0, 8'h00);
      if (clkOut) highs++;
    end
    check(tag, highs, expected);
  endtask

  initial begin
    rst = 1'b1; refEdge = 1'b0; wrEn = 1'b0; wrAddr = 1'b0; wrData = 8'h00;
    mPhase = 0; mDuty = 8'h47; mShift = 0; mDouble = 0;
    sDuty = 8'h47; sShift = 0; sDouble = 0; mOut = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      check("R9", clkOut, 0);
    end
    tagOverride = "R9";
    idle(33);
    tagOverride = "";

    countHigh(8'h64, 13, "R1");
    countHigh(8'hF0, 31, "R1");
    countHigh(8'hFF, 31, "R4");
    countHigh(8'h3C, 5, "R2");
    countHigh(8'h97, 19, "R3");

    tagOverride = "R8";
    configure(8'h47, 0, 0);
    idle(9);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    idle(40);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    idle(3);
    tagOverride = "";

    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 256; d++) begin
        tagOverride = "R7";
        configure(d, m & 1, (m >> 1) & 1);
        idle(30);
        tagOverride = "";
        step(1'b1, 1'b0, 1'b0, 8'h00);
        idle(32);
      end
    end

    tagOverride = "R9";
    configure(8'hC3, 1, 0);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9", clkOut, 0);
    @(posedge clk); @(negedge clk);
    check("R9", clkOut, 0);
    mPhase = 0; mDuty = 8'h47; mShift = 0; mDouble = 0;
    sDuty = 8'h47; sShift = 0; sDouble = 0; mOut = 1'b0;
    idle(40);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule